// File: doc/BRIEF.md
# Boundary-Scan Driven Register Bus Master

This block lets a host reach a chip's internal parallel register bus through the boundary-scan port. It takes the signals a user-instruction scan primitive exposes (test clock, serial in, select, capture, shift and update) and drives a register bus. That bus has an address, a write-data bus with an output enable, a read-data input, and separate read and write strobes. The host shifts a command frame holding the operation, the address and the write data. On the update pulse, the frame crosses into the system clock domain and the block runs one strobe window of fixed length.

With the default configuration, one scan register carries the whole frame. The result of a read leaves on the serial output during the frame that follows, so a run of reads costs one frame per access plus one frame to drain. The next address can be taken from an internal counter instead of the frame. A host can therefore load an address once and then stream reads or writes to consecutive locations. A parameter selects a two-register arrangement instead: one user instruction holds the command and address, and a second one moves the data word.

The captured frame reports whether the bus engine is still busy, and whether the previous frame was dropped because it arrived while a cycle was running.

Top module: `jbus_master`

## Requirements
- R1: In single-register mode (DUAL_IR=0) the frame is shifted LSB first: bit 0 write flag, bit 1 increment flag, bit 2 address-load flag, bits 18:3 address, bits 34:19 data. On update with sel_a high (sel_b low), a write frame drives the data field onto bus_wdata at the chosen address with bus_wr high.
- R2: A read frame samples bus_rdata in the last strobe cycle. The value is returned in bits 34:19 of the next captured frame, and it persists until the next read completes.
- R3: The captured status occupies bits 18:0: bit 0 busy, bit 1 overrun, bit 2 always 0, bits 18:3 the current address counter.
- R4: Each accepted frame produces exactly one strobe pulse of STROBE_CYCLES system clocks. bus_rd and bus_wr are never high together, and bus_addr and bus_wdata stay constant within a pulse.
- R5: bus_oe is high only while bus_wr is high.
- R6: When the increment flag of the running frame is set, the address counter advances by one after the access. A frame with the address-load flag at 0 uses the counter and ignores its own address field.
- R7: With the increment flag at 0 the counter keeps its value after an access. A frame with the address-load flag at 1 replaces the counter before its access.
- R8: An update that arrives while a strobe window is running is dropped with no bus activity, and the overrun bit is set. The next accepted frame clears the overrun bit.
- R9: With DUAL_IR=1, sel_a selects a 19-bit command register with the R1 layout of bits 18:0, capturing the R3 status. sel_b selects a 16-bit data register that captures the read result. Each sel_b update starts an access using the held command, after which the held address-load flag reads as 0.
- R10: After reset the strobes and bus_oe are low, and the address counter, read result, busy and overrun are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the bus side |
| rst | input | 1 | Synchronous active-high reset, applied to both clock domains |
| tck | input | 1 | Test clock from the scan primitive |
| tdi | input | 1 | Serial data into the selected scan register |
| tdo | output | 1 | Serial data out of the selected scan register |
| sel_a | input | 1 | First user instruction selected |
| sel_b | input | 1 | Second user instruction selected (data register when DUAL_IR=1) |
| capture | input | 1 | Capture state of the scan controller |
| shift | input | 1 | Shift state of the scan controller |
| update | input | 1 | Update state of the scan controller |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 16 | Write data driven toward the bus |
| bus_oe | output | 1 | Output enable for bus_wdata |
| bus_rdata | input | 16 | Read data from the bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |

## Verification
A wrong address counter shows at the next capture, in status bits 18:3 and in the location a data-only frame touches. A fault in read sampling shows one frame later, as a wrong data field. If the crossing or the strobe timer loses count, the strobe pulse is too short or too long on the pins within the same access. A busy flag that clears early lets a back-to-back update through, so the write appears at the bus instead of being dropped. The next two captures show this through the overrun bit and the read data.

// File: rtl/jbus_pkg.sv
package jbus_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int CMD_W   = 3 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;

    // LSB first on the wire: wr, inc, load, address
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              load;
        logic              inc;
        logic              wr;
    } cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        cmd_t              cmd;
    } req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              zero;
        logic              overrun;
        logic              busy;
    } stat_t;

    typedef enum logic {ST_IDLE, ST_STROBE} bus_st_e;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic inc);
        return inc ? a + 1'b1 : a;
    endfunction
endpackage

// File: rtl/jbus_scan.sv
module jbus_scan
    import jbus_pkg::*;
#(
    parameter bit DUAL_IR = 1'b0
) (
    input  logic              rst,
    input  logic              tck,
    input  logic              tdi,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  stat_t             stat,
    input  logic [DATA_W-1:0] rdata,
    output logic              tdo,
    output req_t              req,
    output logic              req_tgl
);
    generate
        if (!DUAL_IR) begin : g_single
            logic [FRAME_W-1:0] sr;
            logic               act;
            assign act = sel_a & ~sel_b;

            always_ff @(posedge tck) begin
                if (rst) begin
                    sr <= '0;
                end else if (act && capture) begin
                    sr <= {rdata, stat};
                end else if (act && shift) begin
                    sr <= {tdi, sr[FRAME_W-1:1]};
                end
            end

            always_ff @(posedge tck) begin
                if (rst) begin
                    req     <= '0;
                    req_tgl <= 1'b0;
                end else if (act && update) begin
                    req     <= req_t'(sr);
                    req_tgl <= ~req_tgl;
                end
            end

            assign tdo = sr[0];
        end else begin : g_dual
            logic [CMD_W-1:0]  csr;
            logic [DATA_W-1:0] dsr;
            cmd_t              held;

            always_ff @(posedge tck) begin
                if (rst) begin
                    csr <= '0;
                end else if (sel_a && capture) begin
                    csr <= stat;
                end else if (sel_a && shift) begin
                    csr <= {tdi, csr[CMD_W-1:1]};
                end
            end

            always_ff @(posedge tck) begin
                if (rst) begin
                    dsr <= '0;
                end else if (sel_b && capture) begin
                    dsr <= rdata;
                end else if (sel_b && shift) begin
                    dsr <= {tdi, dsr[DATA_W-1:1]};
                end
            end

            always_ff @(posedge tck) begin
                if (rst) begin
                    held    <= '0;
                    req     <= '0;
                    req_tgl <= 1'b0;
                end else if (sel_a && update) begin
                    held <= cmd_t'(csr);
                end else if (sel_b && update) begin
                    req       <= '{data: dsr, cmd: held};
                    req_tgl   <= ~req_tgl;
                    held.load <= 1'b0;
                end
            end

            assign tdo = sel_b ? dsr[0] : csr[0];
        end
    endgenerate
endmodule

// File: rtl/jbus_tsync.sv
module jbus_tsync (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);
    logic [2:0] s;

    always_ff @(posedge clk) begin
        if (rst) s <= '0;
        else     s <= {s[1:0], tgl_in};
    end

    assign pulse = s[2] ^ s[1];
endmodule

// File: rtl/jbus_engine.sv
module jbus_engine
    import jbus_pkg::*;
#(
    parameter int STROBE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  req_t              req,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    output stat_t             stat,
    output logic [DATA_W-1:0] rdata
);
    localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;

    bus_st_e           state;
    logic [CW-1:0]     cnt;
    logic              cur_wr;
    logic              cur_inc;
    logic [DATA_W-1:0] cur_data;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur_wr   <= 1'b0;
            cur_inc  <= 1'b0;
            cur_data <= '0;
            addr_q   <= '0;
            rdata_q  <= '0;
            ovr_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        cur_wr   <= req.cmd.wr;
                        cur_inc  <= req.cmd.inc;
                        cur_data <= req.data;
                        if (req.cmd.load) addr_q <= req.cmd.addr;
                        cnt      <= CW'(STROBE_CYCLES - 1);
                        ovr_q    <= 1'b0;
                        state    <= ST_STROBE;
                    end
                end
                default: begin
                    if (go) ovr_q <= 1'b1;
                    if (cnt == '0) begin
                        if (!cur_wr) rdata_q <= bus_rdata;
                        addr_q <= step_addr(addr_q, cur_inc);
                        state  <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign bus_rd    = (state == ST_STROBE) && !cur_wr;
    assign bus_wr    = (state == ST_STROBE) && cur_wr;
    assign bus_oe    = bus_wr;
    assign bus_addr  = addr_q;
    assign bus_wdata = cur_data;
    assign rdata     = rdata_q;
    assign stat      = '{addr: addr_q, zero: 1'b0, overrun: ovr_q,
                         busy: (state == ST_STROBE)};
endmodule

// File: rtl/jbus_master.sv
module jbus_master
    import jbus_pkg::*;
#(
    parameter int STROBE_CYCLES = 2,
    parameter bit DUAL_IR       = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tck,
    input  logic              tdi,
    output logic              tdo,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd,
    output logic              bus_wr
);
    req_t              req;
    logic              req_tgl;
    logic              go;
    stat_t             stat;
    logic [DATA_W-1:0] rdata;
    logic              busy_w;
    logic              ovr_w;

    jbus_scan #(.DUAL_IR(DUAL_IR)) u_scan (
        .rst(rst), .tck(tck), .tdi(tdi), .sel_a(sel_a), .sel_b(sel_b),
        .capture(capture), .shift(shift), .update(update),
        .stat(stat), .rdata(rdata), .tdo(tdo), .req(req), .req_tgl(req_tgl)
    );

    jbus_tsync u_sync (
        .clk(clk), .rst(rst), .tgl_in(req_tgl), .pulse(go)
    );

    jbus_engine #(.STROBE_CYCLES(STROBE_CYCLES)) u_eng (
        .clk(clk), .rst(rst), .go(go), .req(req), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_oe(bus_oe),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .stat(stat), .rdata(rdata)
    );

    assign busy_w = stat.busy;
    assign ovr_w  = stat.overrun;
endmodule

// File: rtl/jbus_master_chk.sv
module jbus_master_chk #(
    parameter int STROBE_CYCLES = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        bus_oe,
    input logic [15:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic        busy,
    input logic        ovr
);
    logic strobe;
    int   run;
    assign strobe = bus_rd | bus_wr;

    always_ff @(posedge clk) begin
        if (rst)         run <= 0;
        else if (strobe) run <= run + 1;
        else             run <= 0;
    end

    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> ($stable(bus_addr) && $stable(bus_wdata)));
    p_len_max_r4: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (run < STROBE_CYCLES));
    p_len_end_r4: assert property (@(posedge clk) disable iff (rst)
        (!strobe && run != 0) |-> (run == STROBE_CYCLES));
    p_oe_release_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |-> !bus_oe);
    p_strobe_busy_r8: assert property (@(posedge clk) disable iff (rst)
        strobe |-> busy);
    p_ovr_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(busy));
endmodule

bind jbus_master jbus_master_chk #(.STROBE_CYCLES(STROBE_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_oe(bus_oe),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy_w), .ovr(ovr_w)
);

// File: tb/sim_jbus_master.sv
module sim_jbus_master;
    localparam int STB = 200;
    localparam int FW  = 35;
    localparam int CW  = 19;
    localparam int DW  = 16;

    typedef struct packed {
        logic        wr;
        logic        inc;
        logic        load;
        logic [15:0] addr;
        logic [15:0] data;
        logic [15:0] exp_addr;
        logic [15:0] exp_data;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{1'b1, 1'b0, 1'b1, 16'h0010, 16'h1234, 16'h0000, 16'h0000},
        '{1'b1, 1'b0, 1'b1, 16'h0011, 16'hBEEF, 16'h0010, 16'h0000},
        '{1'b0, 1'b0, 1'b1, 16'h0010, 16'h0000, 16'h0011, 16'h0000},
        '{1'b0, 1'b0, 1'b1, 16'h0011, 16'h0000, 16'h0010, 16'h1234},
        '{1'b1, 1'b1, 1'b1, 16'h0020, 16'h0A0A, 16'h0011, 16'hBEEF},
        '{1'b1, 1'b1, 1'b0, 16'h7777, 16'h0B0B, 16'h0021, 16'hBEEF},
        '{1'b1, 1'b1, 1'b0, 16'h0000, 16'h0C0C, 16'h0022, 16'hBEEF},
        '{1'b0, 1'b1, 1'b1, 16'h0020, 16'h0000, 16'h0023, 16'hBEEF},
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0021, 16'h0A0A},
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0022, 16'h0B0B},
        '{1'b0, 1'b0, 1'b1, 16'h0011, 16'h0000, 16'h0023, 16'h0C0C},
        '{1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0011, 16'hBEEF},
        '{1'b1, 1'b0, 1'b1, 16'h0030, 16'h5555, 16'h0011, 16'hBEEF}
    };

    logic clk = 1'b0, tck = 1'b0, rst = 1'b1;
    logic tdi = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0;
    logic s0a = 1'b0, s1a = 1'b0, s1b = 1'b0;
    logic tdo0, tdo1;
    logic [15:0] a0, w0, r0, a1, w1, r1;
    logic oe0, rd0, wr0, oe1, rd1, wr1;
    logic [15:0] mem0 [256];
    logic [15:0] mem1 [256];

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always #20 tck = ~tck;

    jbus_master #(.STROBE_CYCLES(STB), .DUAL_IR(1'b0)) u0 (
        .clk(clk), .rst(rst), .tck(tck), .tdi(tdi), .tdo(tdo0),
        .sel_a(s0a), .sel_b(1'b0), .capture(capture), .shift(shift),
        .update(update), .bus_addr(a0), .bus_wdata(w0), .bus_oe(oe0),
        .bus_rdata(r0), .bus_rd(rd0), .bus_wr(wr0)
    );

    jbus_master #(.STROBE_CYCLES(STB), .DUAL_IR(1'b1)) u1 (
        .clk(clk), .rst(rst), .tck(tck), .tdi(tdi), .tdo(tdo1),
        .sel_a(s1a), .sel_b(s1b), .capture(capture), .shift(shift),
        .update(update), .bus_addr(a1), .bus_wdata(w1), .bus_oe(oe1),
        .bus_rdata(r1), .bus_rd(rd1), .bus_wr(wr1)
    );

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem0[i] = 16'h0000;
            mem1[i] = 16'h0000;
        end
    end

    always @(posedge clk) begin
        if (wr0 && oe0) mem0[a0[7:0]] <= w0;
        if (wr1 && oe1) mem1[a1[7:0]] <= w1;
    end
    assign r0 = mem0[a0[7:0]];
    assign r1 = mem1[a1[7:0]];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // strobe pulse monitor on u0 (R4, R5)
    int  run_len = 0;
    bit  run_wr  = 1'b0;
    bit  oe_bad  = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rd0 || wr0) begin
                run_len++;
                run_wr = wr0;
                if (oe0 != wr0) oe_bad = 1'b1;
            end else begin
                if (oe0) oe_bad = 1'b1;
                if (run_len != 0) begin
                    chk(run_len == STB, "R4", "strobe pulse length", 64'(run_len), 64'(STB));
                    if (run_wr) chk(!oe_bad, "R5", "output enable outside write strobe",
                                    64'(oe_bad), 64'd0);
                    run_len = 0;
                    oe_bad  = 1'b0;
                end
            end
        end
    end

    // which: 0 = u0 frame, 1 = u1 command, 2 = u1 data
    task automatic scan(input int which, input int len, input logic [63:0] din,
                        output logic [63:0] dout);
        dout = '0;
        repeat (4) @(negedge tck);
        s0a = (which == 0);
        s1a = (which == 1);
        s1b = (which == 2);
        capture = 1'b1;
        @(negedge tck);
        capture = 1'b0;
        shift = 1'b1;
        for (int i = 0; i < len; i++) begin
            dout[i] = (which == 0) ? tdo0 : tdo1;
            tdi = din[i];
            @(negedge tck);
        end
        shift = 1'b0;
        update = 1'b1;
        @(negedge tck);
        update = 1'b0;
        s0a = 1'b0; s1a = 1'b0; s1b = 1'b0;
    endtask

    task automatic settle();
        repeat (STB + 20) @(posedge clk);
    endtask

    function automatic logic [63:0] frm(input logic wr, input logic inc, input logic ld,
                                        input logic [15:0] ad, input logic [15:0] dt);
        return 64'({dt, ad, ld, inc, wr});
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] r;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(!rd0 && !wr0 && !oe0, "R10", "bus idle in reset", {rd0, wr0, oe0}, 0);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!rd0 && !wr0 && !oe0, "R10", "bus idle after reset", {rd0, wr0, oe0}, 0);

        // vector table: R1, R2, R3, R6, R7, R10
        foreach (VEC[i]) begin
            scan(0, FW, frm(VEC[i].wr, VEC[i].inc, VEC[i].load, VEC[i].addr, VEC[i].data), r);
            chk(r[18:3] == VEC[i].exp_addr, "R3/R6/R7", $sformatf("vec %0d address", i),
                r[18:3], VEC[i].exp_addr);
            chk(r[34:19] == VEC[i].exp_data, "R2/R1", $sformatf("vec %0d read data", i),
                r[34:19], VEC[i].exp_data);
            chk(r[2:0] == 3'b000, "R3", $sformatf("vec %0d status bits", i), r[2:0], 0);
            settle();
        end

        // overrun: R8
        scan(0, FW, frm(1'b1, 1'b0, 1'b1, 16'h0040, 16'h1111), r);
        scan(0, FW, frm(1'b1, 1'b0, 1'b1, 16'h0041, 16'h2222), r);
        chk(r[0] == 1'b1, "R8", "busy seen during running window", r[0], 1);
        settle();
        scan(0, FW, frm(1'b0, 1'b0, 1'b1, 16'h0041, 16'h0000), r);
        chk(r[1:0] == 2'b10, "R8", "overrun set, busy clear", r[1:0], 2'b10);
        settle();
        scan(0, FW, frm(1'b0, 1'b0, 1'b1, 16'h0040, 16'h0000), r);
        chk(r[34:19] == 16'h0000, "R8", "dropped write left no trace", r[34:19], 0);
        chk(r[1] == 1'b0, "R8", "overrun cleared by accepted frame", r[1], 0);
        settle();
        scan(0, FW, frm(1'b0, 1'b0, 1'b1, 16'h0030, 16'h0000), r);
        chk(r[34:19] == 16'h1111, "R8", "first write still performed", r[34:19], 16'h1111);
        settle();
        scan(0, FW, frm(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000), r);
        chk(r[34:19] == 16'h5555, "R1", "table write landed", r[34:19], 16'h5555);
        settle();

        // two-register mode: R9
        scan(1, CW, frm(1'b1, 1'b1, 1'b1, 16'h0005, 16'h0000), r);
        settle();
        scan(2, DW, 64'h0000_AAAA, r);
        settle();
        scan(2, DW, 64'h0000_BBBB, r);
        settle();
        scan(1, CW, frm(1'b0, 1'b1, 1'b1, 16'h0005, 16'h0000), r);
        chk(r[18:3] == 16'h0007, "R9", "command status address", r[18:3], 16'h0007);
        settle();
        scan(2, DW, 64'h0, r);
        chk(r[15:0] == 16'h0000, "R9", "first data capture", r[15:0], 0);
        settle();
        scan(2, DW, 64'h0, r);
        chk(r[15:0] == 16'hAAAA, "R9", "read of word 5", r[15:0], 16'hAAAA);
        settle();
        scan(2, DW, 64'h0, r);
        chk(r[15:0] == 16'hBBBB, "R9", "read of word 6", r[15:0], 16'hBBBB);
        settle();
        scan(1, CW, frm(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000), r);
        chk(r[18:3] == 16'h0008, "R9", "counter after burst", r[18:3], 16'h0008);

        repeat (10) @(posedge clk);
        finish_run();
    end
endmodule